// File: doc/BRIEF.md
# Dimension-Order Route Computation Unit

This unit sits at one input of a torus router node whose rings carry traffic in a single direction, and whose dimensions each offer a high and a low virtual channel sharing one physical link. For every header flit it works out, from the destination coordinates in the header and the node's own coordinates, which output the message takes and which of the two virtual channels it uses. The outputs are one ring dimension per dimension, plus a local sink. Because the storage of the router sits behind the outputs, the route is settled here, before any buffering. The flit is then handed on with its output tag already attached.

Dimensions are served from the highest index down. A message leaves on a lower dimension only once no hops remain in any higher one. The virtual channel is chosen so that the channel-dependency cycle of each ring is broken. While the rest of the trip in the chosen dimension still has to cross the ring's wraparound link, the message uses the low channel. Once no such crossing is left, it uses the high channel. The decision reads nothing but the header, never the occupancy of the router.

Flits after the header are not routed again. They carry the tag latched from their header until the tail flit passes. The local sink is a single channel: a header bound for it waits until the sink is free, and from then on the unit holds it until that message's tail has gone through.

Top module: `dor_route_unit`

## Requirements
- R1: For a header, out_port is the highest dimension index d whose hop count (dest[d] - own[d]) mod k is nonzero. Lower dimensions have no influence while a higher one still has hops. Coordinate field d occupies bits [d*CW +: CW] of in_dest and my_coord, and every coordinate is below k.
- R2: A header whose coordinates all equal the node's own is given out_port = NDIM (the sink code), with out_vc_high = 0.
- R3: For a dimension output, out_vc_high = 0 (low channel) when dest[d] < own[d], because the remaining path wraps around. It is 1 (high channel) when dest[d] > own[d].
- R4: A non-header flit (in_head = 0) is not routed. It leaves with the out_port and out_vc_high of the most recent header, whatever its in_dest holds.
- R5: A flit accepted at a clock edge (in_valid and in_ready both high) appears on the outputs with out_valid = 1 right after that edge, with its in_head and in_tail copied to out_head and out_tail. Without a new accept, out_valid drops after an edge where out_ready was high.
- R6: While out_valid = 1 and out_ready = 0, every output field holds its value and in_ready is 0.
- R7: A header for the sink is not accepted while sink_avail = 0. After such a header is accepted without its tail, sink_hold = 1. Flits that follow are then accepted regardless of sink_avail. sink_hold returns to 0 after the tail is accepted.
- R8: After reset, out_valid = 0 and sink_hold = 0.
- R9: A single-flit message (in_head and in_tail both 1) is routed like any header and leaves no sink claim behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| my_coord | input | NDIM*CW | Coordinates of this node, dimension d in bits [d*CW +: CW] |
| in_valid | input | 1 | Input flit present |
| in_ready | output | 1 | Input flit taken at the next edge |
| in_head | input | 1 | Flit is a message header |
| in_tail | input | 1 | Flit is the last of its message |
| in_dest | input | NDIM*CW | Destination coordinates, significant on headers only |
| sink_avail | input | 1 | Local sink free to be claimed |
| out_valid | output | 1 | Tagged flit present on the output |
| out_ready | input | 1 | Downstream buffer takes the output flit |
| out_port | output | PW | Output index: 0..NDIM-1 ring dimension, NDIM sink |
| out_vc_high | output | 1 | 1 selects the high channel, 0 the low channel |
| out_head | output | 1 | Copy of in_head for the output flit |
| out_tail | output | 1 | Copy of in_tail for the output flit |
| sink_hold | output | 1 | Sink claimed by the message in flight |

## Verification
The hardest case to reach is a sink-bound header arriving while the sink is taken, with output backpressure at the same time. That is where the sink gate and the output stall have to combine into one in_ready. It also has to be shown that body flits of a sink message keep moving after sink_avail drops again. Directed sequences set up these cases explicitly. A long random phase then drives out_ready and sink_avail independently, with destinations biased towards the node's own coordinates so that sink routes and equal higher dimensions come up often. A reference model in the bench is compared against the outputs on every cycle.

// File: rtl/dor_pkg.sv
package dor_pkg;
   // virtual channel class on a ring link
   typedef enum logic {
      VC_LOW  = 1'b0,
      VC_HIGH = 1'b1
   } vc_class_e;

   // width of a coordinate for a ring of radix k
   function automatic int coord_bits(input int radix);
      return (radix < 2) ? 1 : $clog2(radix);
   endfunction
endpackage

// File: rtl/dor_hop_calc.sv
module dor_hop_calc #(
   parameter int RADIX_K = 8,
   parameter int CW      = 3
) (
   input  logic [CW-1:0] cur_c,
   input  logic [CW-1:0] dst_c,
   output logic          hops_left,
   output logic          wraps
);
   localparam int HW = CW + 1;
   localparam logic [HW-1:0] K_EXT = HW'(RADIX_K);

   logic [HW-1:0] hop;

   // hop count in the single positive direction, modulo k
   always_comb begin
      if (dst_c >= cur_c) hop = {1'b0, dst_c} - {1'b0, cur_c};
      else                hop = {1'b0, dst_c} + K_EXT - {1'b0, cur_c};
      hops_left = (hop != '0);
      wraps     = (dst_c < cur_c);
   end
endmodule

// File: rtl/dor_dim_select.sv
module dor_dim_select #(
   parameter int NDIM = 3,
   parameter int PW   = 2
) (
   input  logic [NDIM-1:0] hops_left,
   input  logic [NDIM-1:0] wraps,
   output logic [PW-1:0]   sel_port,
   output logic            sel_vc_high,
   output logic            sel_sink
);
   import dor_pkg::*;
   localparam logic [PW-1:0] SINK_CODE = PW'(NDIM);

   // ascending scan, so the highest dimension with hops left wins
   always_comb begin
      sel_port    = SINK_CODE;
      sel_vc_high = VC_LOW;
      for (int d = 0; d < NDIM; d++) begin
         if (hops_left[d]) begin
            sel_port    = PW'(d);
            sel_vc_high = wraps[d] ? VC_LOW : VC_HIGH;
         end
      end
      sel_sink = ~|hops_left;
   end
endmodule

// File: rtl/dor_flow_ctrl.sv
module dor_flow_ctrl #(
   parameter int PW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic          in_head,
   input  logic          in_tail,
   input  logic [PW-1:0] rt_port,
   input  logic          rt_vc_high,
   input  logic          rt_sink,
   input  logic          sink_avail,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [PW-1:0] out_port,
   output logic          out_vc_high,
   output logic          out_head,
   output logic          out_tail,
   output logic          sink_hold
);
   logic          out_free;
   logic          sink_block;
   logic          accept;
   logic [PW-1:0] lat_port;
   logic          lat_vc;

   always_comb begin
      out_free   = !out_valid || out_ready;
      sink_block = in_valid && in_head && rt_sink && !sink_avail;
      in_ready   = out_free && !sink_block;
      accept     = in_valid && in_ready;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_port    <= '0;
         out_vc_high <= 1'b0;
         out_head    <= 1'b0;
         out_tail    <= 1'b0;
         lat_port    <= '0;
         lat_vc      <= 1'b0;
         sink_hold   <= 1'b0;
      end else if (accept) begin
         out_valid   <= 1'b1;
         out_head    <= in_head;
         out_tail    <= in_tail;
         out_port    <= in_head ? rt_port    : lat_port;
         out_vc_high <= in_head ? rt_vc_high : lat_vc;
         if (in_head) begin
            lat_port <= rt_port;
            lat_vc   <= rt_vc_high;
         end
         if (in_tail)                sink_hold <= 1'b0;
         else if (in_head && rt_sink) sink_hold <= 1'b1;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   // R5
   accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);

   // R6
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_port) && $stable(out_vc_high)
                                 && $stable(out_head) && $stable(out_tail));

   // R4
   body_inherit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && !in_head |=> out_port == $past(lat_port)
                                          && out_vc_high == $past(lat_vc));

   // R7
   sink_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sink_hold) |-> $past(sink_avail));

   // R7
   sink_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && in_tail |=> !sink_hold);
endmodule

// File: rtl/dor_route_unit.sv
module dor_route_unit #(
   parameter int NDIM    = 3,
   parameter int RADIX_K = 8,
   parameter int CW      = dor_pkg::coord_bits(RADIX_K),
   parameter int PW      = $clog2(NDIM + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NDIM*CW-1:0]   my_coord,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic                 in_head,
   input  logic                 in_tail,
   input  logic [NDIM*CW-1:0]   in_dest,
   input  logic                 sink_avail,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [PW-1:0]        out_port,
   output logic                 out_vc_high,
   output logic                 out_head,
   output logic                 out_tail,
   output logic                 sink_hold
);
   localparam logic [PW-1:0] SINK_CODE = PW'(NDIM);

   // elaboration-time parameter checks
   if (NDIM < 1) begin : g_bad_ndim
      $error("dor_route_unit: NDIM must be at least 1");
   end
   if (RADIX_K < 2) begin : g_bad_radix
      $error("dor_route_unit: RADIX_K must be at least 2");
   end
   if ((1 << CW) < RADIX_K) begin : g_bad_cw
      $error("dor_route_unit: CW too narrow for RADIX_K");
   end
   if ((1 << PW) < NDIM + 1) begin : g_bad_pw
      $error("dor_route_unit: PW too narrow for NDIM outputs plus sink");
   end

   logic [NDIM-1:0] hops_left;
   logic [NDIM-1:0] wraps;
   logic [PW-1:0]   rt_port;
   logic            rt_vc_high;
   logic            rt_sink;

   for (genvar d = 0; d < NDIM; d++) begin : g_dim
      dor_hop_calc #(.RADIX_K(RADIX_K), .CW(CW)) u_hop (
         .cur_c     (my_coord[d*CW +: CW]),
         .dst_c     (in_dest[d*CW +: CW]),
         .hops_left (hops_left[d]),
         .wraps     (wraps[d])
      );

      // R1
      coord_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid && in_head |-> (32'(in_dest[d*CW +: CW]) < RADIX_K)
                                 && (32'(my_coord[d*CW +: CW]) < RADIX_K));
   end

   dor_dim_select #(.NDIM(NDIM), .PW(PW)) u_sel (
      .hops_left   (hops_left),
      .wraps       (wraps),
      .sel_port    (rt_port),
      .sel_vc_high (rt_vc_high),
      .sel_sink    (rt_sink)
   );

   dor_flow_ctrl #(.PW(PW)) u_flow (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_ready    (in_ready),
      .in_head     (in_head),
      .in_tail     (in_tail),
      .rt_port     (rt_port),
      .rt_vc_high  (rt_vc_high),
      .rt_sink     (rt_sink),
      .sink_avail  (sink_avail),
      .out_valid   (out_valid),
      .out_ready   (out_ready),
      .out_port    (out_port),
      .out_vc_high (out_vc_high),
      .out_head    (out_head),
      .out_tail    (out_tail),
      .sink_hold   (sink_hold)
   );

   // R2
   sink_vc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_port == SINK_CODE |-> !out_vc_high);

   // R1
   port_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_port <= SINK_CODE);
endmodule

// File: tb/dor_route_unit_tb.sv
module dor_route_unit_tb;
   localparam int NDIM = 3;
   localparam int K    = 8;
   localparam int CW   = 3;
   localparam int PW   = 2;
   localparam int AW   = NDIM * CW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] my_coord = '0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic          in_head = 1'b0;
   logic          in_tail = 1'b0;
   logic [AW-1:0] in_dest = '0;
   logic          sink_avail;
   logic          out_valid;
   logic          out_ready;
   logic [PW-1:0] out_port;
   logic          out_vc_high;
   logic          out_head;
   logic          out_tail;
   logic          sink_hold;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   bit   rnd       = 1'b0;
   logic ready_fix = 1'b1;
   logic avail_fix = 1'b1;
   logic rnd_ready = 1'b1;
   logic rnd_avail = 1'b1;

   assign out_ready  = rnd ? rnd_ready : ready_fix;
   assign sink_avail = rnd ? rnd_avail : avail_fix;

   always #2 clk = ~clk;   // 250 MHz

   dor_route_unit u_dut (
      .clk(clk), .rst_n(rst_n), .my_coord(my_coord),
      .in_valid(in_valid), .in_ready(in_ready), .in_head(in_head), .in_tail(in_tail),
      .in_dest(in_dest), .sink_avail(sink_avail),
      .out_valid(out_valid), .out_ready(out_ready), .out_port(out_port),
      .out_vc_high(out_vc_high), .out_head(out_head), .out_tail(out_tail),
      .sink_hold(sink_hold)
   );

   function automatic logic [AW-1:0] pack(input int c2, input int c1, input int c0);
      return {CW'(c2), CW'(c1), CW'(c0)};
   endfunction

   // behavioural route: highest differing dimension, low channel if it wraps
   function automatic void route(input logic [AW-1:0] dst, input logic [AW-1:0] me,
                                 output int p, output int v);
      p = NDIM; v = 0;
      for (int d = NDIM - 1; d >= 0; d--) begin
         int a, b;
         a = int'(dst[d*CW +: CW]);
         b = int'(me[d*CW +: CW]);
         if (((a - b + K) % K) != 0) begin
            p = d; v = (a > b) ? 1 : 0;
            return;
         end
      end
   endfunction

   // reference model state
   int m_ov = 0, m_port = 0, m_vc = 0, m_head = 0, m_tail = 0;
   int m_lport = 0, m_lvc = 0, m_hold = 0;

   function automatic int model_ready();
      int p, v;
      route(in_dest, my_coord, p, v);
      return ((m_ov == 0) || out_ready) &&
             !(in_valid && in_head && (p == NDIM) && !sink_avail);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ov = 0; m_port = 0; m_vc = 0; m_head = 0; m_tail = 0;
         m_lport = 0; m_lvc = 0; m_hold = 0;
      end else begin
         int p, v, rdy;
         route(in_dest, my_coord, p, v);
         rdy = model_ready();
         if (in_valid && rdy) begin
            m_ov = 1; m_head = in_head; m_tail = in_tail;
            if (in_head) begin m_lport = p; m_lvc = v; end
            m_port = m_lport; m_vc = m_lvc;
            if (in_tail) m_hold = 0;
            else if (in_head && p == NDIM) m_hold = 1;
         end else if (out_ready) begin
            m_ov = 0;
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always begin
      @(negedge clk);
      #1;
      if (rst_n && !done) begin
         chk("R5 out_valid", int'(out_valid), m_ov);
         chk("R7 sink_hold", int'(sink_hold), m_hold);
         chk("R6 in_ready", int'(in_ready), model_ready());
         if (m_ov != 0) begin
            chk("R1 out_port", int'(out_port), m_port);
            chk("R3 out_vc_high", int'(out_vc_high), m_vc);
            chk("R5 out_head", int'(out_head), m_head);
            chk("R5 out_tail", int'(out_tail), m_tail);
         end
      end
   end

   always @(negedge clk) begin
      rnd_ready <= ($urandom_range(0, 3) != 0);
      rnd_avail <= ($urandom_range(0, 9) < 7);
   end

   // drive a flit from a negedge and return at the negedge after its accept
   task automatic send(input logic h, input logic t, input logic [AW-1:0] d);
      logic r;
      in_valid = 1'b1; in_head = h; in_tail = t; in_dest = d;
      forever begin
         #1;
         r = in_ready;
         @(negedge clk);
         if (r) break;
      end
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      my_coord = pack(1, 5, 2);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R8 reset out_valid", int'(out_valid), 0);
      chk("R8 reset sink_hold", int'(sink_hold), 0);
      @(negedge clk);

      // R2 / R9: own coordinates, single flit
      send(1, 1, pack(1, 5, 2)); #1;
      chk("R2 sink port", int'(out_port), NDIM);
      chk("R2 sink vc", int'(out_vc_high), 0);
      chk("R9 no claim", int'(sink_hold), 0);
      @(negedge clk);

      // R1 / R3: top dimension, no wrap, then body flits
      send(1, 0, pack(4, 0, 0)); #1;
      chk("R1 dim2", int'(out_port), 2);
      chk("R3 high", int'(out_vc_high), 1);
      @(negedge clk);
      send(0, 0, pack(1, 5, 2)); #1;
      chk("R4 body port", int'(out_port), 2);
      chk("R4 body vc", int'(out_vc_high), 1);
      @(negedge clk);
      send(0, 1, pack(0, 0, 0)); #1;
      chk("R4 tail port", int'(out_port), 2);
      chk("R5 tail flag", int'(out_tail), 1);
      @(negedge clk);

      // R3: wraparound in dimension 2
      send(1, 1, pack(0, 5, 2)); #1;
      chk("R3 wrap low", int'(out_vc_high), 0);
      @(negedge clk);
      // R1: dimension 1 chosen, dimension 0 ignored
      send(1, 1, pack(1, 3, 7)); #1;
      chk("R1 dim1", int'(out_port), 1);
      chk("R3 dim1 low", int'(out_vc_high), 0);
      @(negedge clk);
      send(1, 1, pack(1, 5, 6)); #1;
      chk("R1 dim0", int'(out_port), 0);
      chk("R3 dim0 high", int'(out_vc_high), 1);
      @(negedge clk);

      // R7: sink busy stalls a sink header
      avail_fix = 1'b0;
      in_valid = 1'b1; in_head = 1'b1; in_tail = 1'b0; in_dest = pack(1, 5, 2);
      #1;
      chk("R7 stall", int'(in_ready), 0);
      repeat (3) @(negedge clk);
      #1;
      chk("R7 nothing passed", int'(out_valid), 0);
      chk("R7 no claim yet", int'(sink_hold), 0);
      @(negedge clk);
      avail_fix = 1'b1;
      send(1, 0, pack(1, 5, 2)); #1;
      chk("R7 claimed", int'(sink_hold), 1);
      chk("R2 sink header", int'(out_port), NDIM);
      @(negedge clk);
      avail_fix = 1'b0;
      send(0, 0, pack(4, 4, 4)); #1;
      chk("R7 body passes", int'(out_port), NDIM);
      @(negedge clk);
      send(0, 1, pack(4, 4, 4)); #1;
      chk("R7 released", int'(sink_hold), 0);
      avail_fix = 1'b1;
      @(negedge clk);

      // R6: backpressure
      ready_fix = 1'b0;
      send(1, 1, pack(4, 5, 2)); #1;
      chk("R6 held valid", int'(out_valid), 1);
      @(negedge clk);
      in_valid = 1'b1; in_head = 1'b1; in_tail = 1'b1; in_dest = pack(1, 6, 2);
      #1;
      chk("R6 in_ready low", int'(in_ready), 0);
      @(negedge clk); #1;
      chk("R6 port stable", int'(out_port), 2);
      chk("R6 tail stable", int'(out_tail), 1);
      @(negedge clk);
      ready_fix = 1'b1;
      send(1, 1, pack(1, 6, 2)); #1;
      chk("R1 after stall", int'(out_port), 1);
      chk("R3 after stall", int'(out_vc_high), 1);
      @(negedge clk);

      // random phase, compared by the model every cycle
      rnd = 1'b1;
      for (int m = 0; m < 3000; m++) begin
         int len;
         logic [AW-1:0] d;
         if (m % 1000 == 0)
            my_coord = pack($urandom_range(0, K-1), $urandom_range(0, K-1), $urandom_range(0, K-1));
         for (int c = 0; c < NDIM; c++)
            d[c*CW +: CW] = ($urandom_range(0, 1) == 0) ? my_coord[c*CW +: CW]
                                                        : CW'($urandom_range(0, K-1));
         len = $urandom_range(1, 4);
         for (int f = 0; f < len; f++) begin
            logic [AW-1:0] junk;
            junk = AW'($urandom_range(0, 511));
            for (int c = 0; c < NDIM; c++)
               if (int'(junk[c*CW +: CW]) >= K) junk[c*CW +: CW] = '0;
            send(f == 0, f == len - 1, (f == 0) ? d : junk);
            if ($urandom_range(0, 3) == 0) @(negedge clk);
         end
      end
      rnd = 1'b0;
      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule